// File: doc/BRIEF.md
# Threshold-Driven Pixel Fetch Buffer

This block is a byte-counted pixel buffer placed between an upstream compositor and a display timing generator. The compositor pushes whole pixels into it. The timing generator pops one pixel per read. The buffer asks for more data with a fetch request while the number of stored bytes is below a full level.

The full level is derived from the buffer depth and the selected pixel format. It keeps back six pixels' worth of bytes, because those pixels may still be in flight from the upstream fetch path when the request drops. The level is presented as two fields, a low 6-bit part and a high part, which a neighbouring block recombines.

Software can flush the buffer with a clear command, which acts only while the block is disabled. An option flushes the buffer at every frame start. A second option latches a sticky underflow flag when the consumer reads more bytes than are stored.

Top module: `pixfetch_fifo`

## Requirements
- R1: After reset, occupancy is 0, fetch_req is 1, uf_flag is 0 and rd_data is 0.
- R2: The full level is DEPTH_BYTES minus 12 for format code 0 (16-bit), minus 14 for code 1 (18-bit), and minus 18 for codes 2 and 3 (24-bit).
- R3: level_lo carries bits 5:0 of the full level, and level_hi carries the full level shifted right by 6.
- R4: fetch_req is 1 exactly while occupancy is below the full level.
- R5: An accepted write adds 2 bytes (code 0) or 3 bytes (codes 1 to 3) to occupancy, and a successful read removes the same number. occupancy shows the count from the cycle after the edge.
- R6: wr_ready is 1 exactly while free bytes (DEPTH_BYTES minus occupancy) are at least one pixel. A write offered while wr_ready is 0 is dropped, and occupancy never exceeds DEPTH_BYTES.
- R7: Pixels leave in the order they entered, with byte 0 as the lowest byte. rd_data is updated one cycle after rd_en and is masked to bits 15:0 (code 0), 17:0 (code 1) or 23:0 (codes 2 and 3).
- R8: cfg_flush empties the buffer on the next edge while cfg_enable is 0. While cfg_enable is 1, cfg_flush has no effect.
- R9: frame_start empties the buffer when cfg_flush_on_frame is 1, and has no effect when it is 0. Any flush drops the reads and writes of that cycle.
- R10: A read when occupancy is below one pixel leaves rd_data and occupancy unchanged. It sets uf_flag only if cfg_uf_detect is 1.
- R11: uf_flag stays set until a cycle with uf_clear at 1. If an underflow and uf_clear occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Block enable; a flush command is honoured only while this is 0 |
| cfg_format | input | 2 | Pixel format: 0 = 16-bit, 1 = 18-bit, 2 or 3 = 24-bit |
| cfg_flush | input | 1 | Flush command |
| cfg_flush_on_frame | input | 1 | Flush the buffer at every frame start |
| cfg_uf_detect | input | 1 | Enable underflow detection |
| frame_start | input | 1 | One-cycle frame start strobe |
| wr_valid | input | 1 | Upstream pixel valid |
| wr_data | input | 24 | Upstream pixel, byte 0 lowest |
| wr_ready | output | 1 | Room for one more pixel |
| fetch_req | output | 1 | Request upstream fetch |
| rd_en | input | 1 | Consumer pops one pixel |
| rd_data | output | 24 | Last pixel popped, masked to the format |
| occupancy | output | LVL_W | Stored bytes |
| level_lo | output | 6 | Full level bits 5:0 |
| level_hi | output | HI_W | Full level bits above 5 |
| uf_flag | output | 1 | Sticky underflow flag |
| uf_clear | input | 1 | Clears uf_flag |

## Verification
The assertions watch several properties on every cycle. Occupancy never passes the depth. A raised fetch request always leaves room for a pixel. A flush while disabled, or a flush at frame start, empties the buffer on the next edge. A starved read leaves the output pixel unchanged, and the underflow flag stays set until it is cleared. The bench scenarios are needed for the rest: the exact full levels and their split into two fields, byte ordering and masking per format, dropping of writes at full, a flush command being ignored while enabled, and a set and a clear of the flag arriving together. A byte-queue model in the bench checks these under random traffic for each format.

// File: rtl/pixfetch_pkg.sv
package pixfetch_pkg;

    localparam int FETCH_LAT_PIX = 6;

    typedef enum logic [1:0] {
        PF_FMT_16  = 2'd0,
        PF_FMT_18  = 2'd1,
        PF_FMT_24  = 2'd2,
        PF_FMT_24B = 2'd3
    } pf_fmt_e;

    function automatic int pix_bits(input logic [1:0] fmt);
        case (fmt)
            PF_FMT_16: return 16;
            PF_FMT_18: return 18;
            default:   return 24;
        endcase
    endfunction

    function automatic logic [1:0] pix_bytes(input logic [1:0] fmt);
        return (fmt == PF_FMT_16) ? 2'd2 : 2'd3;
    endfunction

    function automatic logic [23:0] pix_mask(input logic [1:0] fmt, input logic [23:0] v);
        case (fmt)
            PF_FMT_16: return {8'h00, v[15:0]};
            PF_FMT_18: return {6'h00, v[17:0]};
            default:   return v;
        endcase
    endfunction

endpackage

// File: rtl/pixfetch_level.sv
module pixfetch_level
    import pixfetch_pkg::*;
#(
    parameter int DEPTH_BYTES = 384,
    parameter int LVL_W       = $clog2(DEPTH_BYTES + 1),
    parameter int HI_W        = LVL_W - 6
) (
    input  logic [1:0]      fmt,
    output logic [5:0]      lvl_lo,
    output logic [HI_W-1:0] lvl_hi
);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH_BYTES);

    logic [LVL_W-1:0] lat_bytes;
    logic [LVL_W-1:0] level;

    always_comb begin
        // bytes still in flight: latency pixels times bits, rounded up to bytes
        lat_bytes = LVL_W'((FETCH_LAT_PIX * pix_bits(fmt) + 7) / 8);
        level     = DEPTH_L - lat_bytes;
        lvl_lo    = level[5:0];
        lvl_hi    = level[LVL_W-1:6];
    end
endmodule

// File: rtl/pixfetch_store.sv
module pixfetch_store
    import pixfetch_pkg::*;
#(
    parameter int DEPTH_BYTES = 384,
    parameter int PTR_W       = $clog2(DEPTH_BYTES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        push,
    input  logic        pop,
    input  logic [1:0]  fmt,
    input  logic [1:0]  bpp,
    input  logic [23:0] wr_data,
    output logic [23:0] rd_data
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [23:0]      rdata;
    } store_t;

    store_t     st_d, st_q;
    logic [7:0] mem [DEPTH_BYTES];

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p, input int n);
        int s;
        s = int'(p) + n;
        if (s >= DEPTH_BYTES) s = s - DEPTH_BYTES;
        return PTR_W'(s);
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp = '0;
            st_d.rp = '0;
        end else begin
            if (push) st_d.wp = adv(st_q.wp, int'(bpp));
            if (pop) begin
                st_d.rp    = adv(st_q.rp, int'(bpp));
                st_d.rdata = pix_mask(fmt, {mem[adv(st_q.rp, 2)],
                                            mem[adv(st_q.rp, 1)],
                                            mem[st_q.rp]});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            for (int k = 0; k < 3; k++) begin
                if (k < int'(bpp)) mem[adv(st_q.wp, k)] <= wr_data[8*k +: 8];
            end
        end
    end

    assign rd_data = st_q.rdata;
endmodule

// File: rtl/pixfetch_fifo.sv
module pixfetch_fifo
    import pixfetch_pkg::*;
#(
    parameter int DEPTH_BYTES = 384,
    parameter int LVL_W       = $clog2(DEPTH_BYTES + 1),
    parameter int HI_W        = LVL_W - 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_format,
    input  logic             cfg_flush,
    input  logic             cfg_flush_on_frame,
    input  logic             cfg_uf_detect,
    input  logic             frame_start,
    input  logic             wr_valid,
    input  logic [23:0]      wr_data,
    output logic             wr_ready,
    output logic             fetch_req,
    input  logic             rd_en,
    output logic [23:0]      rd_data,
    output logic [LVL_W-1:0] occupancy,
    output logic [5:0]       level_lo,
    output logic [HI_W-1:0]  level_hi,
    output logic             uf_flag,
    input  logic             uf_clear
);
    localparam int               PTR_W   = $clog2(DEPTH_BYTES);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH_BYTES);

    typedef struct packed {
        logic [LVL_W-1:0] occ;
        logic             uf;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [1:0]       bpp;
    logic [LVL_W-1:0] bpp_w;
    logic [LVL_W-1:0] full_level;
    logic             flush, push, pop, starve;

    pixfetch_level #(.DEPTH_BYTES(DEPTH_BYTES), .LVL_W(LVL_W), .HI_W(HI_W)) u_level (
        .fmt    (cfg_format),
        .lvl_lo (level_lo),
        .lvl_hi (level_hi)
    );

    pixfetch_store #(.DEPTH_BYTES(DEPTH_BYTES), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push    (push),
        .pop     (pop),
        .fmt     (cfg_format),
        .bpp     (bpp),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    always_comb begin
        bpp        = pix_bytes(cfg_format);
        bpp_w      = LVL_W'(bpp);
        full_level = {level_hi, level_lo};
        flush      = (cfg_flush && !cfg_enable) || (frame_start && cfg_flush_on_frame);
        wr_ready   = (DEPTH_L - ctl_q.occ) >= bpp_w;
        fetch_req  = ctl_q.occ < full_level;
        push       = wr_valid && wr_ready && !flush;
        pop        = rd_en && (ctl_q.occ >= bpp_w) && !flush;
        starve     = rd_en && (ctl_q.occ < bpp_w) && !flush;

        ctl_d = ctl_q;
        if (flush) begin
            ctl_d.occ = '0;
        end else begin
            ctl_d.occ = ctl_q.occ + (push ? bpp_w : '0) - (pop ? bpp_w : '0);
        end
        if (starve && cfg_uf_detect) ctl_d.uf = 1'b1;
        else if (uf_clear)           ctl_d.uf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign occupancy = ctl_q.occ;
    assign uf_flag   = ctl_q.uf;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= DEPTH_L); // R6
    AST_REQ_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> wr_ready); // R4
    AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flush && !cfg_enable) |=> (occupancy == '0)); // R8
    AST_FRAME_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cfg_flush_on_frame) |=> (occupancy == '0)); // R9
    AST_STARVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && occupancy < bpp_w) |=> $stable(rd_data)); // R10
    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !uf_clear) |=> uf_flag); // R11
endmodule

// File: tb/tb_pixfetch_fifo.sv
module tb_pixfetch_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int D     = 384;
    localparam int LVL_W = $clog2(D + 1);
    localparam int HI_W  = LVL_W - 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_enable, cfg_flush, cfg_flush_on_frame, cfg_uf_detect, frame_start;
    logic [1:0] cfg_format;
    logic wr_valid, wr_ready, fetch_req, rd_en, uf_flag, uf_clear;
    logic [23:0] wr_data, rd_data;
    logic [LVL_W-1:0] occupancy;
    logic [5:0] level_lo;
    logic [HI_W-1:0] level_hi;

    int errors = 0, checks = 0;
    logic [7:0] mq[$];
    logic [23:0] exp_rd = '0;
    logic exp_uf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixfetch_fifo #(.DEPTH_BYTES(D)) dut (.*);

    function automatic int bpp_of(input logic [1:0] f);
        return (f == 2'd0) ? 2 : 3;
    endfunction
    function automatic int lvl_of(input logic [1:0] f);
        return D - ((f == 2'd0) ? 12 : (f == 2'd1) ? 14 : 18);
    endfunction
    function automatic logic [23:0] mask_of(input logic [1:0] f, input logic [23:0] v);
        return (f == 2'd0) ? (v & 24'h00ffff) : (f == 2'd1) ? (v & 24'h03ffff) : v;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int b;
        b = bpp_of(cfg_format);
        chk(req, "occupancy", 32'(occupancy), 32'(mq.size()));
        chk(req, "fetch_req", 32'(fetch_req), 32'(mq.size() < lvl_of(cfg_format)));
        chk(req, "wr_ready", 32'(wr_ready), 32'((D - mq.size()) >= b));
        chk(req, "rd_data", 32'(rd_data), 32'(exp_rd));
        chk(req, "uf_flag", 32'(uf_flag), 32'(exp_uf));
    endtask

    task automatic model_step();
        int b, sz;
        logic fl, wok, uset;
        logic [23:0] v;
        b = bpp_of(cfg_format);
        sz = mq.size();
        uset = 1'b0;
        fl = (cfg_flush && !cfg_enable) || (frame_start && cfg_flush_on_frame);
        if (fl) mq.delete();
        else begin
            wok = wr_valid && ((D - sz) >= b);
            if (rd_en) begin
                if (sz >= b) begin
                    v = '0;
                    for (int k = 0; k < b; k++) v[8*k +: 8] = mq.pop_front();
                    exp_rd = mask_of(cfg_format, v);
                end else if (cfg_uf_detect) uset = 1'b1;
            end
            if (wok) for (int k = 0; k < b; k++) mq.push_back(wr_data[8*k +: 8]);
        end
        if (uset) exp_uf = 1'b1;
        else if (uf_clear) exp_uf = 1'b0;
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        cfg_flush = 0; frame_start = 0; wr_valid = 0; rd_en = 0; uf_clear = 0;
    endtask

    task automatic flush_now(input logic [1:0] f);
        idle_inputs();
        cfg_enable = 0; cfg_flush = 1; cycle();
        cfg_flush = 0; cfg_enable = 1; cfg_format = f; #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        cfg_enable = 1; cfg_format = 2'd2; cfg_flush_on_frame = 0; cfg_uf_detect = 1;
        wr_data = '0;
        idle_inputs();
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        check_all("R1");

        for (int f = 0; f < 4; f++) begin
            cfg_format = 2'(f); #1;
            chk("R2", "full level", 32'({level_hi, level_lo}), 32'(lvl_of(2'(f))));
            chk("R3", "level_lo", 32'(level_lo), 32'(lvl_of(2'(f)) & 63));
            chk("R3", "level_hi", 32'(level_hi), 32'(lvl_of(2'(f)) >> 6));
        end
        cfg_format = 2'd2; #1;

        // R5 R4 fill to full
        wr_valid = 1;
        for (int i = 0; i < 200 && wr_ready; i++) begin
            wr_data = $urandom; cycle(); check_all("R5");
        end
        // R6 write at full dropped
        wr_data = 24'habcdef; cycle(); check_all("R6");
        chk("R6", "occ at full", 32'(occupancy), 32'(D));
        wr_valid = 0;
        // R7 order
        rd_en = 1;
        for (int i = 0; i < 10; i++) begin cycle(); check_all("R7"); end
        rd_en = 0;
        // R8 flush while enabled ignored, then disabled
        cfg_flush = 1; cycle(); check_all("R8");
        cfg_enable = 0; cycle(); check_all("R8");
        cfg_flush = 0; cfg_enable = 1;
        // R9
        wr_valid = 1;
        for (int i = 0; i < 4; i++) begin wr_data = $urandom; cycle(); end
        wr_valid = 0; frame_start = 1; cycle(); check_all("R9");
        cfg_flush_on_frame = 1; cycle(); check_all("R9");
        frame_start = 0; cfg_flush_on_frame = 0;
        // R10 starved reads
        cfg_uf_detect = 0; rd_en = 1; cycle(); check_all("R10");
        cfg_uf_detect = 1; cycle(); check_all("R10");
        rd_en = 0;
        // R11 sticky, clear, set wins
        repeat (3) begin cycle(); check_all("R11"); end
        uf_clear = 1; cycle(); check_all("R11");
        rd_en = 1; cycle(); check_all("R11");
        rd_en = 0; uf_clear = 0;

        // R7 narrow formats
        for (int f = 0; f < 2; f++) begin
            flush_now(2'(f));
            wr_valid = 1;
            for (int i = 0; i < 3; i++) begin wr_data = $urandom; cycle(); check_all("R5"); end
            wr_valid = 0; rd_en = 1;
            for (int i = 0; i < 4; i++) begin cycle(); check_all("R7"); end
            rd_en = 0;
        end

        // random traffic per format
        for (int f = 0; f < 4; f++) begin
            flush_now(2'(f));
            for (int i = 0; i < 1500; i++) begin
                wr_valid = (i < 750) ? (($urandom % 4) != 0) : (($urandom % 3) == 0);
                rd_en    = (i < 750) ? (($urandom % 3) == 0) : (($urandom % 4) != 0);
                wr_data  = $urandom;
                uf_clear = (($urandom % 16) == 0);
                cfg_uf_detect = (($urandom % 8) != 0);
                frame_start = (($urandom % 97) == 0);
                cfg_flush_on_frame = (($urandom % 2) == 0);
                cycle();
                check_all("R4 R5 R6 R7 R10 R11");
            end
            idle_inputs();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule